// File: doc/BRIEF.md
# Class-Selector Dispatch Address Generator

This block turns a message send into a call address for a small 16-bit object machine. Each class keeps all of its code in one vector. The front of that vector is a row of two-word slots, one slot per selector. An invalid class/selector pair still has a slot, and that slot jumps to the not-understood routine, so a send always lands on a real address and the block never reports a miss.

The class comes straight from the top bits of the receiver pointer, so no memory read is needed. A small register file holds one code-vector base address per class. The call address is the base of the receiver's class plus twice the selector number. It is registered and appears, with a call strobe, on the clock after the send.

A programmable selector limit marks the current table width. A send whose selector is at or above the limit produces a bad-selector flag instead of an address. Base entries and the limit are rewritten through simple write ports when classes are regenerated.

Top module: `dsp_send_target`

## Requirements
- R1: While reset is active and on the first clock after it, call_valid, bad_selector and call_target are all 0. Reset clears every base entry to 0 and sets the selector limit to 2^SEL_W, so every selector is in range.
- R2: The receiver class is recv_ptr[15:11], giving 32 classes. recv_ptr[10:0] has no effect on the call address.
- R3: For an in-range send, call_target on the next clock equals base[class] + 2*selector.
- R4: call_valid is 1 exactly on the clock after a cycle with send_valid=1 and selector < limit, and 0 otherwise.
- R5: A send with selector >= limit sets bad_selector on the next clock, keeps call_valid at 0 and leaves call_target unchanged.
- R6: call_target holds its value on every clock without a valid call.
- R7: With base_we=1, base_data is written to entry base_cls. Sends on later clocks see the new value. A send in the same cycle as the write sees the old value.
- R8: With lim_we=1, lim_data becomes the selector limit. Sends on later clocks are judged against it. A send in the same cycle as the write is judged against the old limit.
- R9: call_valid and bad_selector are never 1 together.
- R10: The address sum wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| send_valid | input | 1 | A send is presented this cycle |
| recv_ptr | input | 16 | Receiver object pointer; class in bits 15:11 |
| selector | input | SEL_W | Selector number |
| base_we | input | 1 | Base entry write enable |
| base_cls | input | 5 | Class whose base entry is written |
| base_data | input | 16 | New code-vector base address |
| lim_we | input | 1 | Selector limit write enable |
| lim_data | input | SEL_W+1 | New selector limit |
| call_valid | output | 1 | Call strobe for call_target |
| call_target | output | 16 | Computed call address |
| bad_selector | output | 1 | Previous send had an out-of-range selector |

## Verification
The assertions assume every input is a known value on each clock edge outside reset. They also assume a write and a send may share a cycle, with the send reading the state as it was before that edge. The stimulus drives all inputs on the falling edge and draws each value from its full width. This covers class indices beyond those written, limits of 0 and of 2^SEL_W, and writes overlapping sends. With these inputs the same-cycle ordering and the boundaries are exercised without driving anything undefined.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  localparam int WORD_W = 16;
  localparam int CLS_W  = 5;
  localparam int NCLS   = 1 << CLS_W;
  localparam int SLOT_W = WORD_W - CLS_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CLS_W-1:0]  cls_t;

  // class is the pointer's top field
  function automatic cls_t cls_of(input word_t ptr);
    return ptr[WORD_W-1 -: CLS_W];
  endfunction

  function automatic logic [SLOT_W-1:0] slot_of(input word_t ptr);
    return ptr[SLOT_W-1:0];
  endfunction

  // two words per entry, sum wraps at word width
  function automatic word_t entry_addr(input word_t base, input word_t sel);
    return word_t'(base + (sel << 1));
  endfunction
endpackage

// File: rtl/dsp_class_decode.sv
module dsp_class_decode
  import dsp_pkg::*;
(
  input  word_t              ptr,
  output cls_t               cls,
  output logic [SLOT_W-1:0]  slot
);
  assign cls  = cls_of(ptr);
  assign slot = slot_of(ptr);
endmodule

// File: rtl/dsp_base_file.sv
module dsp_base_file
  import dsp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  cls_t  wr_cls,
  input  word_t wr_data,
  input  cls_t  rd_cls,
  output word_t rd_data
);
  word_t ent [NCLS];

  for (genvar g = 0; g < NCLS; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)                                  ent[g] <= '0;
      else if (we && wr_cls == cls_t'(g))          ent[g] <= wr_data;
    end
  end

  assign rd_data = ent[rd_cls];
endmodule

// File: rtl/dsp_limit_check.sv
module dsp_limit_check #(
  parameter int SEL_W = 10,
  localparam int LIM_W = SEL_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [LIM_W-1:0] wr_data,
  input  logic [SEL_W-1:0] sel,
  output logic [LIM_W-1:0] limit,
  output logic             in_range
);
  localparam logic [LIM_W-1:0] FULL = LIM_W'(1) << SEL_W;

  always_ff @(posedge clk) begin
    if (!rst_n)  limit <= FULL;
    else if (we) limit <= wr_data;
  end

  assign in_range = {1'b0, sel} < limit;
endmodule

// File: rtl/dsp_send_target.sv
module dsp_send_target
  import dsp_pkg::*;
#(
  parameter int SEL_W = 10,
  localparam int LIM_W = SEL_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             send_valid,
  input  logic [15:0]      recv_ptr,
  input  logic [SEL_W-1:0] selector,
  input  logic             base_we,
  input  logic [4:0]       base_cls,
  input  logic [15:0]      base_data,
  input  logic             lim_we,
  input  logic [LIM_W-1:0] lim_data,
  output logic             call_valid,
  output logic [15:0]      call_target,
  output logic             bad_selector
);
  cls_t              cls_idx;
  logic [SLOT_W-1:0] obj_slot;
  word_t             base_rd;
  logic [LIM_W-1:0]  limit_q;
  logic              sel_ok;
  word_t             addr_nx;
  logic              fire;
  logic              reject;

  dsp_class_decode u_dec (.ptr(recv_ptr), .cls(cls_idx), .slot(obj_slot));

  dsp_base_file u_base (
    .clk(clk), .rst_n(rst_n), .we(base_we), .wr_cls(base_cls),
    .wr_data(base_data), .rd_cls(cls_idx), .rd_data(base_rd)
  );

  dsp_limit_check #(.SEL_W(SEL_W)) u_lim (
    .clk(clk), .rst_n(rst_n), .we(lim_we), .wr_data(lim_data),
    .sel(selector), .limit(limit_q), .in_range(sel_ok)
  );

  assign addr_nx = entry_addr(base_rd, word_t'(selector));
  assign fire    = send_valid & sel_ok;
  assign reject  = send_valid & ~sel_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      call_valid   <= 1'b0;
      bad_selector <= 1'b0;
      call_target  <= '0;
    end else begin
      call_valid   <= fire;
      bad_selector <= reject;
      if (fire) call_target <= addr_nx;
    end
  end
endmodule

// File: rtl/dsp_send_target_chk.sv
module dsp_send_target_chk
  import dsp_pkg::*;
#(
  parameter int SEL_W = 10,
  localparam int LIM_W = SEL_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              send_valid,
  input logic [15:0]       recv_ptr,
  input logic [SEL_W-1:0]  selector,
  input cls_t              cls_idx,
  input logic [SLOT_W-1:0] obj_slot,
  input word_t             base_rd,
  input logic [LIM_W-1:0]  limit_q,
  input logic              call_valid,
  input logic [15:0]       call_target,
  input logic              bad_selector
);
  p_class_from_ptr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    send_valid |-> ({cls_idx, obj_slot} == recv_ptr));

  p_strobe_needs_send_r4: assert property (@(posedge clk) disable iff (!rst_n)
    call_valid |-> $past(send_valid) && ({1'b0, $past(selector)} < $past(limit_q)));

  p_bad_needs_over_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bad_selector |-> $past(send_valid) && ({1'b0, $past(selector)} >= $past(limit_q)));

  p_target_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !call_valid |-> $stable(call_target));

  p_even_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    call_valid |-> (call_target[0] == $past(base_rd[0])));

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(call_valid && bad_selector));
endmodule

bind dsp_send_target dsp_send_target_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .send_valid(send_valid), .recv_ptr(recv_ptr),
  .selector(selector), .cls_idx(cls_idx), .obj_slot(obj_slot),
  .base_rd(base_rd), .limit_q(limit_q), .call_valid(call_valid),
  .call_target(call_target), .bad_selector(bad_selector)
);

// File: tb/test_dsp_send_target.sv
module test_dsp_send_target;
  localparam int SEL_W = 10;
  localparam int LIM_W = SEL_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic send_valid = 1'b0;
  logic [15:0] recv_ptr = '0;
  logic [SEL_W-1:0] selector = '0;
  logic base_we = 1'b0;
  logic [4:0] base_cls = '0;
  logic [15:0] base_data = '0;
  logic lim_we = 1'b0;
  logic [LIM_W-1:0] lim_data = '0;
  logic call_valid, bad_selector;
  logic [15:0] call_target;

  always #5 clk = ~clk;

  dsp_send_target #(.SEL_W(SEL_W)) i_dsp_send_target (.*);

  int vectors = 0, errors = 0;
  int base_m [32];
  int lim_m;
  bit exp_v, exp_b;
  int exp_t;

  task automatic chk(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // compare at the falling edge, then drive the next cycle and advance the model
  task automatic step(string tag, bit v, int ptr, int sel,
                      bit bwe = 0, int bcls = 0, int bdat = 0,
                      bit lwe = 0, int ldat = 0);
    @(negedge clk);
    chk(tag, "call_valid R4", call_valid, exp_v);
    chk(tag, "bad_selector R5", bad_selector, exp_b);
    chk(tag, "call_target R3", call_target, exp_t);
    send_valid = v; recv_ptr = 16'(ptr); selector = SEL_W'(sel);
    base_we = bwe; base_cls = 5'(bcls); base_data = 16'(bdat);
    lim_we = lwe; lim_data = LIM_W'(ldat);
    begin
      int c = (ptr & 16'hFFFF) / 2048;
      int s = sel % (1 << SEL_W);
      bit ok = s < lim_m;
      exp_v = v && ok;
      exp_b = v && !ok;
      if (exp_v) exp_t = (base_m[c] + 2 * s) % 65536;
    end
    if (bwe) base_m[bcls % 32] = bdat & 16'hFFFF;
    if (lwe) lim_m = ldat % (1 << LIM_W);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    foreach (base_m[i]) base_m[i] = 0;
    lim_m = 1 << SEL_W;
    exp_v = 0; exp_b = 0; exp_t = 0;
    repeat (3) @(negedge clk);
    // R1 outputs during reset
    chk("R1", "call_valid", call_valid, 0);
    chk("R1", "bad_selector", bad_selector, 0);
    chk("R1", "call_target", call_target, 0);
    rst_n = 1'b1;
    // R1 bases are 0 and every selector is in range after reset
    step("R1", 1, 16'h3800, 1023);
    step("R1", 0, 0, 0);
    // R7 write class 2 base, send in same cycle sees old 0
    step("R7", 1, 16'h1000, 4, 1, 2, 16'h0400);
    step("R7", 1, 16'h1000, 4);
    step("R2", 1, 16'h17FF, 4);            // low bits ignored, class 2
    step("R2", 1, 16'h0800, 4, 1, 1, 16'h2000);
    step("R3", 1, 16'h0800, 7);
    @(negedge clk);
    chk("R3", "literal target", call_target, 16'h200E);
    // R10 wraparound: base FFFE + 2*5 = 0008
    step("R10", 1, 16'h1800, 0, 1, 3, 16'hFFFE);
    step("R10", 1, 16'h1800, 5);
    step("R6", 0, 16'h1800, 9);
    @(negedge clk);
    chk("R10", "wrapped target", call_target, 16'h0008);
    // R8 limit write, same-cycle send judged against old limit
    step("R8", 1, 16'h0800, 20, 0, 0, 0, 1, 16);
    step("R5", 1, 16'h0800, 16);
    step("R5", 1, 16'h0800, 15);
    step("R9", 1, 16'h0800, 16);
    step("R6", 0, 0, 0);
    step("R8", 1, 16'h0800, 0, 0, 0, 0, 1, 0);
    step("R8", 1, 16'h0800, 0);
    step("R8", 1, 16'h0800, 1023, 0, 0, 0, 1, 1 << SEL_W);
    step("R8", 1, 16'h0800, 1023);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      step("R3", $urandom_range(0, 3) != 0, $urandom_range(0, 65535),
           $urandom_range(0, (1 << SEL_W) - 1),
           $urandom_range(0, 3) == 0, $urandom_range(0, 31), $urandom_range(0, 65535),
           $urandom_range(0, 40) == 0, $urandom_range(0, 1 << SEL_W));
    end
    step("R6", 0, 0, 0);
    step("R6", 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule